// File: doc/BRIEF.md
# Memory Interface Register Block

This block sits between a microcoded datapath and two memory ports. It holds the word-address and word-data registers for a 32-bit data port. It also holds the byte-address counter and the byte buffer for an 8-bit instruction-fetch port. The control unit loads the address and data registers from the result bus. It raises read, write or fetch strobes. The block turns each strobe into a one-cycle request toward memory, captures the returned word or byte, and presents the buffered byte to the operand bus either sign-extended or zero-extended.

Timing is fixed and has no handshake with back-pressure. A strobe raised in cycle k produces a request that is valid for exactly cycle k+1. The memory must accept every request and must answer a read or fetch within that same cycle, by raising its response-valid line. The answer is captured at the end of cycle k+1, so the datapath can use it in cycle k+2. The memory side has no ready line. A memory that cannot keep this pace cannot be attached. A response-valid that arrives with no request outstanding is discarded. Reads and fetches run on separate ports and may overlap.

Top module: `memif_regs`

## Requirements
- R1: While rst_n is low and after its release, mar_q, mdr_q, pc_q and the byte buffer are zero (mbr_bus reads 0), and dreq_valid and freq_valid are 0.
- R2: At a rising edge, ld_mar, ld_pc and ld_mdr each copy c_bus into their register. A register whose load is low keeps its value, unless R4 applies to mdr_q.
- R3: rd high in cycle k makes dreq_valid=1 and dreq_write=0 in cycle k+1, with dreq_addr equal to mar_q as loaded at the end of cycle k. A load of the address register in cycle k is included.
- R4: When dresp_valid is high during a read request cycle, dresp_data appears on mdr_q in the next cycle. A response overrides an ld_mdr in the same cycle.
- R5: wr high (rd low) in cycle k makes dreq_valid=1 and dreq_write=1 in cycle k+1. dreq_addr and dreq_wdata equal mar_q and mdr_q as they stand after the edge that ends cycle k.
- R6: rd and wr high together issue a read only (dreq_write=0).
- R7: fetch high in cycle k makes freq_valid=1 in cycle k+1, with freq_addr equal to pc_q after that edge. A byte returned with fresp_valid in cycle k+1 is held in the byte buffer from cycle k+2.
- R8: A read and a fetch may be outstanding in the same cycle, and each completes as if alone.
- R9: mbr_oe_signed=1 puts the buffer on mbr_bus with bit 7 copied into bits 31..8. mbr_oe_unsigned=1 (with signed low) puts the buffer there with bits 31..8 zero. With both low, mbr_bus is 0.
- R10: dresp_valid or fresp_valid with no matching read or fetch outstanding leaves mdr_q and the byte buffer unchanged.
- R11: Each request valid lasts one cycle. With no strobe in cycle k, the matching valid is 0 in cycle k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| c_bus | input | 32 | Result bus from the shifter |
| ld_mar | input | 1 | Load word-address register from c_bus |
| ld_mdr | input | 1 | Load word-data register from c_bus |
| ld_pc | input | 1 | Load byte-address register from c_bus |
| rd | input | 1 | Word read strobe |
| wr | input | 1 | Word write strobe |
| fetch | input | 1 | Byte fetch strobe |
| mbr_oe_signed | input | 1 | Drive buffer sign-extended |
| mbr_oe_unsigned | input | 1 | Drive buffer zero-extended |
| mar_q | output | 32 | Word-address register |
| mdr_q | output | 32 | Word-data register |
| pc_q | output | 32 | Byte-address register |
| mbr_bus | output | 32 | Extended byte buffer toward the operand bus |
| dreq_valid | output | 1 | Data request valid |
| dreq_write | output | 1 | Data request is a write |
| dreq_addr | output | 32 | Data word address |
| dreq_wdata | output | 32 | Data write word |
| dresp_valid | input | 1 | Read data valid |
| dresp_data | input | 32 | Read data word |
| freq_valid | output | 1 | Fetch request valid |
| freq_addr | output | 32 | Fetch byte address |
| fresp_valid | input | 1 | Fetch byte valid |
| fresp_byte | input | 8 | Fetched byte |

## Verification
A wrong request-kind register shows one cycle after the strobe, on dreq_valid or dreq_write. A stale address or data capture shows in that same cycle on dreq_addr or dreq_wdata. A broken capture path for returned data shows on mdr_q or mbr_bus two cycles after the strobe. A response accepted with no request outstanding corrupts the register one cycle later. A wrong extension choice is visible at once, because mbr_bus is combinational from the select lines.

// File: rtl/memif_pkg.sv
package memif_pkg;

  typedef enum logic [1:0] {
    REQ_IDLE  = 2'd0,
    REQ_READ  = 2'd1,
    REQ_WRITE = 2'd2
  } wreq_kind_e;

  // read wins over write when both strobes are raised
  function automatic wreq_kind_e req_kind(input logic rd_i, input logic wr_i);
    if (rd_i)      return REQ_READ;
    else if (wr_i) return REQ_WRITE;
    else           return REQ_IDLE;
  endfunction

endpackage

// File: rtl/memif_word_port.sv
module memif_word_port
  import memif_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] c_bus,
  input  logic          ld_mar,
  input  logic          ld_mdr,
  input  logic          rd,
  input  logic          wr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic [DW-1:0] mar_q,
  output logic [DW-1:0] mdr_q,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata
);

  logic [DW-1:0] mar_r, mdr_r, mar_d, mdr_c, mdr_d;
  logic [AW-1:0] addr_r;
  logic [DW-1:0] wdata_r;
  wreq_kind_e    kind_q, kind_d;
  logic          land;

  always_comb begin
    mar_d  = ld_mar ? c_bus : mar_r;
    mdr_c  = ld_mdr ? c_bus : mdr_r;
    land   = (kind_q == REQ_READ) && rsp_valid;
    mdr_d  = land ? rsp_data : mdr_c;
    kind_d = req_kind(rd, wr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar_r   <= '0;
      mdr_r   <= '0;
      kind_q  <= REQ_IDLE;
      addr_r  <= '0;
      wdata_r <= '0;
    end else begin
      mar_r   <= mar_d;
      mdr_r   <= mdr_d;
      kind_q  <= kind_d;
      addr_r  <= mar_d[AW-1:0];
      wdata_r <= mdr_d;
    end
  end

  assign mar_q     = mar_r;
  assign mdr_q     = mdr_r;
  assign req_valid = (kind_q != REQ_IDLE);
  assign req_write = (kind_q == REQ_WRITE);
  assign req_addr  = addr_r;
  assign req_wdata = wdata_r;

endmodule

// File: rtl/memif_byte_port.sv
module memif_byte_port #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] c_bus,
  input  logic          ld_pc,
  input  logic          fetch,
  input  logic          rsp_valid,
  input  logic [BW-1:0] rsp_byte,
  output logic [DW-1:0] pc_q,
  output logic [BW-1:0] mbr_q,
  output logic          req_valid,
  output logic [AW-1:0] req_addr
);

  logic [DW-1:0] pc_r, pc_d;
  logic [BW-1:0] mbr_r, mbr_d;
  logic          pend_q;
  logic [AW-1:0] addr_r;

  always_comb begin
    pc_d  = ld_pc ? c_bus : pc_r;
    mbr_d = (pend_q && rsp_valid) ? rsp_byte : mbr_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_r   <= '0;
      mbr_r  <= '0;
      pend_q <= 1'b0;
      addr_r <= '0;
    end else begin
      pc_r   <= pc_d;
      mbr_r  <= mbr_d;
      pend_q <= fetch;
      addr_r <= pc_d[AW-1:0];
    end
  end

  assign pc_q      = pc_r;
  assign mbr_q     = mbr_r;
  assign req_valid = pend_q;
  assign req_addr  = addr_r;

endmodule

// File: rtl/memif_byte_ext.sv
module memif_byte_ext #(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic [BW-1:0] byte_i,
  input  logic          oe_signed,
  input  logic          oe_unsigned,
  output logic [DW-1:0] bus_o
);

  localparam int FILL = DW - BW;

  logic [DW-1:0] sx, zx;

  generate
    if (FILL > 0) begin : g_widen
      assign sx = {{FILL{byte_i[BW-1]}}, byte_i};
      assign zx = {{FILL{1'b0}}, byte_i};
    end else begin : g_same
      assign sx = byte_i[DW-1:0];
      assign zx = byte_i[DW-1:0];
    end
  endgenerate

  always_comb begin
    if (oe_signed)        bus_o = sx;
    else if (oe_unsigned) bus_o = zx;
    else                  bus_o = '0;
  end

endmodule

// File: rtl/memif_regs.sv
module memif_regs #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] c_bus,
  input  logic          ld_mar,
  input  logic          ld_mdr,
  input  logic          ld_pc,
  input  logic          rd,
  input  logic          wr,
  input  logic          fetch,
  input  logic          mbr_oe_signed,
  input  logic          mbr_oe_unsigned,
  output logic [DW-1:0] mar_q,
  output logic [DW-1:0] mdr_q,
  output logic [DW-1:0] pc_q,
  output logic [DW-1:0] mbr_bus,
  output logic          dreq_valid,
  output logic          dreq_write,
  output logic [AW-1:0] dreq_addr,
  output logic [DW-1:0] dreq_wdata,
  input  logic          dresp_valid,
  input  logic [DW-1:0] dresp_data,
  output logic          freq_valid,
  output logic [AW-1:0] freq_addr,
  input  logic          fresp_valid,
  input  logic [BW-1:0] fresp_byte
);

  logic [BW-1:0] mbr_q;

  memif_word_port #(.DW(DW), .AW(AW)) u_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .c_bus     (c_bus),
    .ld_mar    (ld_mar),
    .ld_mdr    (ld_mdr),
    .rd        (rd),
    .wr        (wr),
    .rsp_valid (dresp_valid),
    .rsp_data  (dresp_data),
    .mar_q     (mar_q),
    .mdr_q     (mdr_q),
    .req_valid (dreq_valid),
    .req_write (dreq_write),
    .req_addr  (dreq_addr),
    .req_wdata (dreq_wdata)
  );

  memif_byte_port #(.DW(DW), .AW(AW), .BW(BW)) u_byte (
    .clk       (clk),
    .rst_n     (rst_n),
    .c_bus     (c_bus),
    .ld_pc     (ld_pc),
    .fetch     (fetch),
    .rsp_valid (fresp_valid),
    .rsp_byte  (fresp_byte),
    .pc_q      (pc_q),
    .mbr_q     (mbr_q),
    .req_valid (freq_valid),
    .req_addr  (freq_addr)
  );

  memif_byte_ext #(.DW(DW), .BW(BW)) u_ext (
    .byte_i      (mbr_q),
    .oe_signed   (mbr_oe_signed),
    .oe_unsigned (mbr_oe_unsigned),
    .bus_o       (mbr_bus)
  );

endmodule

// File: rtl/memif_regs_chk.sv
module memif_regs_chk #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_mar,
  input logic          ld_mdr,
  input logic          rd,
  input logic          wr,
  input logic          fetch,
  input logic          mbr_oe_signed,
  input logic          mbr_oe_unsigned,
  input logic [DW-1:0] mar_q,
  input logic [DW-1:0] mdr_q,
  input logic [DW-1:0] mbr_bus,
  input logic          dreq_valid,
  input logic          dreq_write,
  input logic [AW-1:0] dreq_addr,
  input logic          dresp_valid,
  input logic [DW-1:0] dresp_data,
  input logic          freq_valid
);

  AST_RD_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (dreq_valid && !dreq_write)); // R3
  AST_RD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (dreq_addr == mar_q[AW-1:0])); // R3
  AST_WR_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd) |=> (dreq_valid && dreq_write)); // R5
  AST_BOTH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rd) |=> !dreq_write); // R6
  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd || wr) |=> !dreq_valid); // R11
  AST_FETCH_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> freq_valid); // R7
  AST_FETCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch |=> !freq_valid); // R11
  AST_READ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_valid && !dreq_write && dresp_valid) |=> (mdr_q == $past(dresp_data))); // R4
  AST_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dreq_valid && !dreq_write) && !ld_mdr) |=> $stable(mdr_q)); // R10
  AST_MAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_mar |=> $stable(mar_q)); // R2
  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mbr_oe_signed && mbr_bus[7]) |-> (&mbr_bus[DW-1:8])); // R9
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!mbr_oe_signed && mbr_oe_unsigned) |-> (mbr_bus[DW-1:8] == '0)); // R9
  AST_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!mbr_oe_signed && !mbr_oe_unsigned) |-> (mbr_bus == '0)); // R9

endmodule

bind memif_regs memif_regs_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ld_mar          (ld_mar),
  .ld_mdr          (ld_mdr),
  .rd              (rd),
  .wr              (wr),
  .fetch           (fetch),
  .mbr_oe_signed   (mbr_oe_signed),
  .mbr_oe_unsigned (mbr_oe_unsigned),
  .mar_q           (mar_q),
  .mdr_q           (mdr_q),
  .mbr_bus         (mbr_bus),
  .dreq_valid      (dreq_valid),
  .dreq_write      (dreq_write),
  .dreq_addr       (dreq_addr),
  .dresp_valid     (dresp_valid),
  .dresp_data      (dresp_data),
  .freq_valid      (freq_valid)
);

// File: tb/memif_regs_test.sv
module memif_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] c_bus = '0;
  logic        ld_mar = 0, ld_mdr = 0, ld_pc = 0;
  logic        rd = 0, wr = 0, fetch = 0;
  logic        oe_s = 0, oe_u = 0;
  logic        spur_d = 0, spur_f = 0;
  logic [31:0] mar_q, mdr_q, pc_q, mbr_bus;
  logic        dreq_valid, dreq_write, freq_valid;
  logic [31:0] dreq_addr, dreq_wdata, freq_addr;
  logic        dresp_valid, fresp_valid;
  logic [31:0] dresp_data;
  logic [7:0]  fresp_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] mem [16];

  always #10 clk = ~clk;

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ 8'hA5;
  endfunction

  assign dresp_valid = (dreq_valid && !dreq_write) || spur_d;
  assign dresp_data  = mem[dreq_addr[3:0]];
  assign fresp_valid = freq_valid || spur_f;
  assign fresp_byte  = fbyte(freq_addr);

  always @(posedge clk)
    if (rst_n && dreq_valid && dreq_write) mem[dreq_addr[3:0]] <= dreq_wdata;

  memif_regs uut (
    .clk(clk), .rst_n(rst_n), .c_bus(c_bus),
    .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_pc(ld_pc),
    .rd(rd), .wr(wr), .fetch(fetch),
    .mbr_oe_signed(oe_s), .mbr_oe_unsigned(oe_u),
    .mar_q(mar_q), .mdr_q(mdr_q), .pc_q(pc_q), .mbr_bus(mbr_bus),
    .dreq_valid(dreq_valid), .dreq_write(dreq_write),
    .dreq_addr(dreq_addr), .dreq_wdata(dreq_wdata),
    .dresp_valid(dresp_valid), .dresp_data(dresp_data),
    .freq_valid(freq_valid), .freq_addr(freq_addr),
    .fresp_valid(fresp_valid), .fresp_byte(fresp_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ext(input logic [7:0] b, input logic s, input logic u);
    if (s)      return {{24{b[7]}}, b};
    else if (u) return {24'h0, b};
    else        return 32'h0;
  endfunction

  // model of the state visible during the current cycle
  logic [31:0] m_mar = 0, m_mdr = 0, m_pc = 0;
  logic [7:0]  m_mbr = 0;
  logic        p_v = 0, p_w = 0, q_v = 0;
  logic [31:0] p_addr = 0, p_wdata = 0, q_addr = 0;
  string       mdr_tag = "R1";
  string       fa_tag  = "R7";

  task automatic drive_and_predict(input logic [31:0] cb, input logic lm, input logic ld,
                                   input logic lp, input logic r, input logic w,
                                   input logic f, input logic s, input logic u,
                                   input logic sd, input logic sf);
    logic [31:0] mdr_c, mar_n, mdr_n, pc_n;
    logic [7:0]  mbr_n;
    c_bus = cb; ld_mar = lm; ld_mdr = ld; ld_pc = lp;
    rd = r; wr = w; fetch = f; oe_s = s; oe_u = u; spur_d = sd; spur_f = sf;
    mar_n = lm ? cb : m_mar;
    mdr_c = ld ? cb : m_mdr;
    mdr_n = (p_v && !p_w) ? mem[p_addr[3:0]] : mdr_c;
    if (p_v && !p_w)           mdr_tag = ld ? "R4 override" : "R4";
    else if (sd)               mdr_tag = "R10";
    else                       mdr_tag = "R2 mdr";
    pc_n  = lp ? cb : m_pc;
    mbr_n = q_v ? fbyte(q_addr) : m_mbr;
    fa_tag = (r && f) ? "R8" : "R7";
    m_mar = mar_n; m_mdr = mdr_n; m_pc = pc_n;
    if (sf && !q_v) mdr_tag = {mdr_tag, "/R10 mbr"};
    m_mbr = mbr_n;
    p_v = r || w; p_w = w && !r; p_addr = mar_n; p_wdata = mdr_n;
    q_v = f; q_addr = pc_n;
  endtask

  task automatic check_all();
    chk("R2 mar", mar_q, m_mar);
    chk("R2 pc", pc_q, m_pc);
    chk(mdr_tag, mdr_q, m_mdr);
    chk("R11 dreq_valid", {31'h0, dreq_valid}, {31'h0, p_v});
    chk("R11 freq_valid", {31'h0, freq_valid}, {31'h0, q_v});
    if (p_v) begin
      chk("R6 dreq_write", {31'h0, dreq_write}, {31'h0, p_w});
      chk("R3 dreq_addr", dreq_addr, p_addr);
      if (p_w) chk("R5 dreq_wdata", dreq_wdata, p_wdata);
    end
    if (q_v) chk(fa_tag, freq_addr, q_addr);
    chk("R9 mbr_bus", mbr_bus, ext(m_mbr, oe_s, oe_u));
  endtask

  task automatic step(input logic [31:0] cb, input logic lm, input logic ld,
                      input logic lp, input logic r, input logic w,
                      input logic f, input logic s, input logic u,
                      input logic sd, input logic sf);
    drive_and_predict(cb, lm, ld, lp, r, w, f, s, u, sd, sf);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0001 * (i + 3) ^ 32'h8000_00F0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mar", mar_q, 0);
    chk("R1 mdr", mdr_q, 0);
    chk("R1 pc", pc_q, 0);
    oe_s = 1; #1;
    chk("R1 mbr_bus", mbr_bus, 0);
    oe_s = 0;
    chk("R1 dreq_valid", {31'h0, dreq_valid}, 0);
    chk("R1 freq_valid", {31'h0, freq_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check_all();
    // directed: load MAR and read in same cycle (R3, R4)
    step(32'h5, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step(32'h0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0); // R4 response beats ld_mdr
    step(32'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // directed: write with same-cycle MDR load (R5)
    step(32'hDEAD_BEEF, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step(32'h0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step(32'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // directed: rd and wr together (R6), fetch of a negative byte (R7, R8, R9)
    step(32'h0000_0003, 1, 0, 1, 1, 1, 1, 0, 0, 0, 0);
    step(32'h0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(32'h0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(32'h0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // directed: stray responses (R10)
    step(32'h0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1);
    step(32'h0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] cb;
      cb = ($urandom % 4 == 0) ? $urandom : ($urandom % 64);
      step(cb, ($urandom % 100) < 35, ($urandom % 100) < 30, ($urandom % 100) < 30,
           ($urandom % 100) < 30, ($urandom % 100) < 25, ($urandom % 100) < 40,
           ($urandom % 2) == 1, ($urandom % 2) == 1,
           ($urandom % 100) < 15, ($urandom % 100) < 15);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule